// File: doc/BRIEF.md
# Single-Character Print Handshake Sink

This block stands in for a slow character printer on the far side of a parallel output controller. While it can take a character, it keeps its ready line high. A one-cycle transfer request then captures the byte on the parallel data input and pulls ready low. Ready stays low for a fixed printing time. When that time has passed, ready goes high again and a one-cycle printed strobe marks the end of the print.

Only one character is ever held. A request that comes while ready is low is dropped, and the held byte stays as it was. This gives the controller the one-character-at-a-time pacing it has to respect. The printing time is a parameter counted in clock cycles. On silicon it can stand for milliseconds, and a bench can shrink it to a handful of cycles.

Top module: `print_handshake_sink`

## Requirements
- R1: While reset is asserted and in the first cycle after it, ready is 1, printed is 0 and held_char is 0.
- R2: With no request, ready stays 1 and printed stays 0.
- R3: A request sampled at a clock edge while ready is 1 makes ready 0 after that edge, and held_char then shows the data sampled at the same edge.
- R4: After an accepted request, ready stays 0 for exactly PRINT_CYCLES cycles and then returns to 1.
- R5: A request sampled while ready is 0 is ignored. It changes neither held_char nor the time at which ready returns to 1.
- R6: Printed is 1 for exactly one cycle, in the same cycle ready returns to 1, and held_char then still shows the printed character.
- R7: A request sampled in the first cycle after ready returns to 1 is accepted, so back-to-back characters lose no cycle.
- R8: A request held high for several cycles counts as a single accepted character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| xfer_req | input | 1 | Transfer request strobe from the controller |
| data_in | input | DATA_W | Parallel character data |
| ready | output | 1 | High while a character can be accepted |
| held_char | output | DATA_W | Character currently held or being printed |
| printed | output | 1 | One-cycle strobe at the end of printing |

## Verification
The assertions assume that reset is held low from time zero until the first edges. They assume no timing of their own on xfer_req, because a request at any moment must be either taken or ignored. The stimulus drives requests and data only on the falling edge, with a random density that lands requests both in the idle state and in the middle of printing. Directed cases add a request held for several cycles and a request in the exact cycle ready comes back, so that each documented corner is reached at least once.

// File: rtl/psink_pkg.sv
// Package psink_pkg: shared types for the print handshake sink.
// Assumes nothing beyond a two-state printer model.
package psink_pkg;
    typedef enum logic {
        PS_IDLE  = 1'b0,
        PS_PRINT = 1'b1
    } psink_state_t;
endpackage

// File: rtl/psink_hold.sv
// Module psink_hold: one-character holding register.
// Loads data_in when load is high and otherwise keeps its value.
// Assumes the caller raises load only when a character is accepted.
module psink_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    // Capture the accepted character; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

    // R5: without a load the held character must not move
    a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));
endmodule

// File: rtl/psink_delay.sv
// Module psink_delay: down counter that measures the printing time.
// load presets it to LOAD_VAL and run counts it down to zero, where it stops.
// zero reports that the count has run out.
// Assumes load and run are not both needed in the same cycle.
module psink_delay #(
    parameter int CNT_W    = 4,
    parameter int LOAD_VAL = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic zero
);
    logic [CNT_W-1:0] cnt;

    // Preset on load, otherwise decrement while running and not yet zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (load)               cnt <= CNT_W'(LOAD_VAL);
        else if (run && cnt != '0)   cnt <= cnt - 1'b1;
    end

    // Flag the end of the count.
    always_comb zero = (cnt == '0);

    // R4: the counter never leaves the programmed range
    a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(LOAD_VAL));
endmodule

// File: rtl/print_handshake_sink.sv
// Module print_handshake_sink: printer model with a one-character buffer.
// It accepts a byte on xfer_req while ready is high, drops ready for
// PRINT_CYCLES cycles, then raises ready together with a one-cycle printed strobe.
// Assumes PRINT_CYCLES >= 1. Requests made while printing are dropped.
module print_handshake_sink
    import psink_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int PRINT_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_req,
    input  logic [DATA_W-1:0] data_in,
    output logic              ready,
    output logic [DATA_W-1:0] held_char,
    output logic              printed
);
    localparam int CNT_W    = (PRINT_CYCLES > 1) ? $clog2(PRINT_CYCLES) : 1;
    localparam int LOAD_VAL = PRINT_CYCLES - 1;

    psink_state_t state;
    logic accept;
    logic finish;
    logic cnt_zero;

    // Decode accept and finish from the current state.
    always_comb begin
        accept = xfer_req && (state == PS_IDLE);
        finish = (state == PS_PRINT) && cnt_zero;
    end

    // Step between idle and printing.
    always_ff @(posedge clk) begin
        if (!rst_n)      state <= PS_IDLE;
        else if (accept) state <= PS_PRINT;
        else if (finish) state <= PS_IDLE;
    end

    // Register the end-of-print strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) printed <= 1'b0;
        else        printed <= finish;
    end

    // Drive ready from the state.
    always_comb ready = (state == PS_IDLE);

    psink_hold #(.DATA_W(DATA_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .d     (data_in),
        .q     (held_char)
    );

    psink_delay #(.CNT_W(CNT_W), .LOAD_VAL(LOAD_VAL)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .run   (state == PS_PRINT),
        .zero  (cnt_zero)
    );

    // R3: an accepted request drops ready on the next cycle
    a_r3_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && ready) |=> !ready);
    // R6: the printed strobe lasts a single cycle
    a_r6_printed_single: assert property (@(posedge clk) disable iff (!rst_n)
        printed |=> !printed);
    // R6: the printed strobe comes with ready high
    a_r6_printed_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        printed |-> ready);
    // R4: ready rises only at the end of a print
    a_r4_rise_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> printed);
endmodule

// File: tb/tb_print_handshake_sink.sv
// Bench for print_handshake_sink: a random request stream plus directed
// corner cases, checked against a cycle model written from the requirements.
module tb_print_handshake_sink;
    localparam int DW = 8;
    localparam int PC = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          xfer_req = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic          ready;
    logic [DW-1:0] held_char;
    logic          printed;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // expected state, kept by the bench
    bit          m_busy = 0;
    int          m_left = 0;
    logic [DW-1:0] m_held = '0;
    bit          m_printed = 0;

    always #2.5 clk = ~clk;

    print_handshake_sink #(.DATA_W(DW), .PRINT_CYCLES(PC)) dut (
        .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .data_in(data_in),
        .ready(ready), .held_char(held_char), .printed(printed)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h expected=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // Expected behaviour per edge: R3 accept, R4 count PC cycles, R5 ignore, R6 strobe.
    function automatic void model_edge(bit req, logic [DW-1:0] d);
        if (m_busy) begin
            if (m_left == 1) begin m_busy = 0; m_printed = 1; end
            else begin m_left--; m_printed = 0; end
        end else begin
            m_printed = 0;
            if (req) begin m_busy = 1; m_left = PC; m_held = d; end
        end
    endfunction

    // Drive for one cycle, update the model at the edge, compare at the falling edge.
    task automatic cyc(bit req, logic [DW-1:0] d);
        xfer_req = req;
        data_in  = d;
        @(posedge clk);
        model_edge(req, d);
        @(negedge clk);
        check("R4 ready", ready, !m_busy);
        check("R3 held_char", held_char, m_held);
        check("R6 printed", printed, m_printed);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check("R1 ready in reset", ready, 1);
        check("R1 printed in reset", printed, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", ready, 1);
        check("R1 held_char after reset", held_char, 0);

        // R2: idle cycles keep ready high
        for (int i = 0; i < 5; i++) begin
            cyc(0, 8'hFF);
            check("R2 idle ready", ready, 1);
            check("R2 idle printed", printed, 0);
        end

        // R5: a request during printing is ignored
        cyc(1, 8'hA5);
        check("R3 captured", held_char, 8'hA5);
        cyc(0, 8'h00);
        cyc(1, 8'h3C);
        check("R5 held kept", held_char, 8'hA5);
        check("R5 still busy", ready, 0);
        while (!m_printed) cyc(0, 8'h00);
        check("R6 printed char", held_char, 8'hA5);

        // R7: a request right after ready returns is accepted
        cyc(1, 8'h5A);
        check("R7 back to back accepted", ready, 0);
        check("R7 new char", held_char, 8'h5A);
        while (!m_printed) cyc(0, 8'h00);

        // R8: a held request counts once
        for (int i = 0; i < 4; i++) cyc(1, 8'(8'h10 + i));
        check("R8 single capture", held_char, 8'h10);
        while (!m_printed) cyc(1, 8'h77);
        cyc(0, 8'h00);

        // R4/R5: random stream
        for (int i = 0; i < 3000; i++)
            cyc(($urandom % 4) == 0, 8'($urandom));

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule